// File: doc/BRIEF.md
# Multi-Mode Operand Fetch Sequencer

This block fetches the source operand for a register-memory ALU instruction. A decoded instruction arrives as a one-cycle `start` strobe with a 4-bit addressing-mode code, base and index register numbers, a 32-bit constant and an operand-size code. The block reads its own eight-entry register file and forms the effective address. It issues zero, one or two reads on a synchronous memory read port with one cycle of latency. It writes back the base register for the post-increment and pre-decrement style modes, and returns the operand with a one-cycle `done` strobe.

The operand size d is 1, 2, 4 or 8 bytes and is coded as log2(d) on `sizeCode`, so index scaling and base stepping are shifts. Mode codes 10 to 15 are reserved. They complete without touching memory and raise `illegal` alongside `done`. An external write port loads the register file. This is the path the ALU result would take.

Top module: `amu_top`

## Requirements
- R1: After reset, `done`, `busy`, `illegal` and `memReq` are low, `operand` is zero, and every register reads as zero.
- R2: Mode 0 (register) returns the base register's contents with no memory read, and `done` rises two clock edges after the `start` edge.
- R3: Mode 1 (immediate) returns `konst` with no memory read, and `done` rises two edges after `start`.
- R4: Mode 2 (displacement) makes one read at `konst` + base, wrapping modulo 2^32, and returns the read data, with `done` three edges after `start`.
- R5: Mode 3 (register indirect) makes one read at the base value. Mode 4 (indexed) makes one read at base + index. Both return the data three edges after `start`.
- R6: Mode 5 (absolute) makes one read at `konst` and returns the data three edges after `start`.
- R7: Mode 6 (memory indirect) makes two back-to-back reads. The first is at the base value, the second is at the word the first one returned, and the result is the second word. `done` rises four edges after `start`, and `memReq` is never high for more than two cycles in a row.
- R8: Mode 7 (auto-increment) makes one read at the old base value, returns the data, and adds d = 2^`sizeCode` to the base register. The update is written on the same edge that raises `done`.
- R9: Mode 8 (auto-decrement) reads at the old base value the same way and subtracts d from the base register on the `done` edge.
- R10: Mode 9 (scaled) makes one read at `konst` + base + (index << `sizeCode`) and returns the data three edges after `start`.
- R11: Mode codes 10 to 15 make no memory read, leave every register unchanged, return zero, and assert `illegal` in the same cycle as `done`. `illegal` is low on every other completion.
- R12: `done` is a one-cycle pulse, and exactly one is produced per accepted `start`. `busy` is high while an instruction is in flight. A `start` while busy is ignored. `operand` changes only in a cycle where `done` is high.
- R13: `regWrEn` writes `regWrData` into register `regWrSel` on the clock edge, and a later register-mode fetch returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Accept a new instruction (ignored while busy) |
| mode | input | 4 | Addressing-mode code, 0 to 9 valid |
| baseSel | input | 3 | Base register number |
| idxSel | input | 3 | Index register number |
| konst | input | 32 | Displacement, absolute address or immediate value |
| sizeCode | input | 2 | log2 of operand size d |
| regWrEn | input | 1 | External register write enable |
| regWrSel | input | 3 | External write register number |
| regWrData | input | 32 | External write data |
| memReq | output | 1 | Memory read request |
| memAddr | output | 32 | Memory read address |
| memRdata | input | 32 | Read data, valid the cycle after the request |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | Reserved mode code seen, valid with done |
| operand | output | 32 | Fetched source operand, held until the next completion |

## Verification
The embedded properties watch the following on every cycle:
- the single-cycle shape of `done`;
- the holding of `operand` between completions;
- the absence of a read in front of an illegal completion;
- the two-read ceiling;
- the refusal of `start` while busy;
- the fact that a base write-back always moves the base register.

Whether each mode forms the correct address, returns the correct word and steps the base by the correct d can only be shown by the scoreboard scenarios. The same holds for the exact completion latency and for visibility of the updated base to the following instruction. Those scenarios compare every completion against a register-file mirror and a computed memory image.

// File: rtl/amu_pkg.sv
package amu_pkg;

  typedef enum logic [3:0] {
    AM_REG    = 4'd0,
    AM_IMM    = 4'd1,
    AM_DISP   = 4'd2,
    AM_RIND   = 4'd3,
    AM_INDEX  = 4'd4,
    AM_ABS    = 4'd5,
    AM_MIND   = 4'd6,
    AM_AINC   = 4'd7,
    AM_ADEC   = 4'd8,
    AM_SCALED = 4'd9
  } amMode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_RD1  = 2'd2,
    ST_RD2  = 2'd3
  } amState_e;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_REG  = 2'd1,
    SRC_IMM  = 2'd2,
    SRC_MEM  = 2'd3
  } opSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   ldInstr;
    logic   useBase;
    logic   useDisp;
    logic   useIdx;
    logic   scaleIdx;
    logic   addrFromData;
    logic   memReq;
    logic   ldOperand;
    opSrc_e opSrc;
    logic   wbEn;
    logic   wbDec;
    logic   fin;
    logic   setIllegal;
  } amuCtl_t;

endpackage

// File: rtl/amu_ctrl.sv
module amu_ctrl
  import amu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [3:0] mode,
  output amuCtl_t    ctl,
  output logic       busy,
  output logic       done,
  output logic       illegal
);

  amState_e stQ, stNxt;
  amMode_e  modeQ;
  logic     doneQ, illQ;

  always_comb begin
    ctl   = '0;
    stNxt = stQ;
    unique case (stQ)
      ST_IDLE: begin
        if (start) begin
          ctl.ldInstr = 1'b1;
          stNxt       = ST_EVAL;
        end
      end
      ST_EVAL: begin
        case (modeQ)
          AM_REG: begin
            ctl.opSrc = SRC_REG; ctl.ldOperand = 1'b1; ctl.fin = 1'b1;
            stNxt = ST_IDLE;
          end
          AM_IMM: begin
            ctl.opSrc = SRC_IMM; ctl.ldOperand = 1'b1; ctl.fin = 1'b1;
            stNxt = ST_IDLE;
          end
          AM_DISP: begin
            ctl.useBase = 1'b1; ctl.useDisp = 1'b1; ctl.memReq = 1'b1;
            stNxt = ST_RD1;
          end
          AM_RIND, AM_MIND, AM_AINC, AM_ADEC: begin
            ctl.useBase = 1'b1; ctl.memReq = 1'b1;
            stNxt = ST_RD1;
          end
          AM_INDEX: begin
            ctl.useBase = 1'b1; ctl.useIdx = 1'b1; ctl.memReq = 1'b1;
            stNxt = ST_RD1;
          end
          AM_ABS: begin
            ctl.useDisp = 1'b1; ctl.memReq = 1'b1;
            stNxt = ST_RD1;
          end
          AM_SCALED: begin
            ctl.useBase = 1'b1; ctl.useDisp = 1'b1; ctl.useIdx = 1'b1;
            ctl.scaleIdx = 1'b1; ctl.memReq = 1'b1;
            stNxt = ST_RD1;
          end
          default: begin
            ctl.opSrc = SRC_ZERO; ctl.ldOperand = 1'b1; ctl.fin = 1'b1;
            ctl.setIllegal = 1'b1;
            stNxt = ST_IDLE;
          end
        endcase
      end
      ST_RD1: begin
        if (modeQ == AM_MIND) begin
          ctl.addrFromData = 1'b1; ctl.memReq = 1'b1;
          stNxt = ST_RD2;
        end else begin
          ctl.opSrc = SRC_MEM; ctl.ldOperand = 1'b1; ctl.fin = 1'b1;
          ctl.wbEn  = (modeQ == AM_AINC) || (modeQ == AM_ADEC);
          ctl.wbDec = (modeQ == AM_ADEC);
          stNxt = ST_IDLE;
        end
      end
      ST_RD2: begin
        ctl.opSrc = SRC_MEM; ctl.ldOperand = 1'b1; ctl.fin = 1'b1;
        stNxt = ST_IDLE;
      end
      default: stNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      modeQ <= AM_REG;
      doneQ <= 1'b0;
      illQ  <= 1'b0;
    end else begin
      stQ   <= stNxt;
      doneQ <= ctl.fin;
      illQ  <= ctl.fin & ctl.setIllegal;
      if (ctl.ldInstr) modeQ <= amMode_e'(mode);
    end
  end

  assign busy    = (stQ != ST_IDLE);
  assign done    = doneQ;
  assign illegal = illQ;

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R12
  start_while_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> $stable(modeQ));

endmodule

// File: rtl/amu_dpath.sv
module amu_dpath
  import amu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 8,
  parameter int SZ_W   = 2,
  localparam int REG_AW = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  amuCtl_t           ctl,
  input  logic [REG_AW-1:0] baseSel,
  input  logic [REG_AW-1:0] idxSel,
  input  logic [DATA_W-1:0] konst,
  input  logic [SZ_W-1:0]   sizeCode,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] operand
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] rf [REG_N];
  logic [REG_AW-1:0] baseQ, idxQ;
  logic [DATA_W-1:0] konstQ, operandQ;
  logic [SZ_W-1:0]   sizeQ;

  logic [DATA_W-1:0] rbRd, riRd, stepD, idxTerm, baseTerm, dispTerm, ea, wbVal;

  assign rbRd = rf[baseQ];
  assign riRd = rf[idxQ];
  assign stepD = ONE << sizeQ;

  assign baseTerm = ctl.useBase ? rbRd : '0;
  assign dispTerm = ctl.useDisp ? konstQ : '0;
  assign idxTerm  = !ctl.useIdx ? '0 : (ctl.scaleIdx ? (riRd << sizeQ) : riRd);
  assign ea       = baseTerm + dispTerm + idxTerm;

  assign memAddr = ctl.addrFromData ? memRdata : ea;
  assign wbVal   = ctl.wbDec ? (rbRd - stepD) : (rbRd + stepD);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      idxQ   <= '0;
      konstQ <= '0;
      sizeQ  <= '0;
    end else if (ctl.ldInstr) begin
      baseQ  <= baseSel;
      idxQ   <= idxSel;
      konstQ <= konst;
      sizeQ  <= sizeCode;
    end
  end

  // base write-back wins over an external write to the same register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < REG_N; k++) rf[k] <= '0;
    end else begin
      if (regWrEn && !(ctl.wbEn && (regWrSel == baseQ))) rf[regWrSel] <= regWrData;
      if (ctl.wbEn) rf[baseQ] <= wbVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      operandQ <= '0;
    end else if (ctl.ldOperand) begin
      unique case (ctl.opSrc)
        SRC_REG:  operandQ <= rbRd;
        SRC_IMM:  operandQ <= konstQ;
        SRC_MEM:  operandQ <= memRdata;
        default:  operandQ <= '0;
      endcase
    end
  end

  assign operand = operandQ;

  // R8
  base_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wbEn |=> (rbRd != $past(rbRd)));

endmodule

// File: rtl/amu_top.sv
module amu_top
  import amu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_N  = 8,
  localparam int REG_AW = $clog2(REG_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [3:0]        mode,
  input  logic [REG_AW-1:0] baseSel,
  input  logic [REG_AW-1:0] idxSel,
  input  logic [DATA_W-1:0] konst,
  input  logic [1:0]        sizeCode,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regWrSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic              memReq,
  output logic [DATA_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdata,
  output logic              busy,
  output logic              done,
  output logic              illegal,
  output logic [DATA_W-1:0] operand
);

  amuCtl_t ctl;

  amu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .mode    (mode),
    .ctl     (ctl),
    .busy    (busy),
    .done    (done),
    .illegal (illegal)
  );

  amu_dpath #(.DATA_W(DATA_W), .REG_N(REG_N), .SZ_W(2)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .baseSel   (baseSel),
    .idxSel    (idxSel),
    .konst     (konst),
    .sizeCode  (sizeCode),
    .regWrEn   (regWrEn),
    .regWrSel  (regWrSel),
    .regWrData (regWrData),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .operand   (operand)
  );

  assign memReq = ctl.memReq;

  // R11
  illegal_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && illegal) |-> !$past(memReq));

  // R12
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(operand) |-> done);

  // R7
  read_burst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && $past(memReq)) |=> !memReq);

endmodule

// File: tb/amu_top_tb.sv
module amu_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [2:0]  baseSel = '0, idxSel = '0, regWrSel = '0;
  logic [31:0] konst = '0, regWrData = '0, memRdata = '0;
  logic [1:0]  sizeCode = '0;
  logic        regWrEn = 1'b0;
  logic        memReq, busy, done, illegal;
  logic [31:0] memAddr, operand;

  always #2 clk = ~clk;

  amu_top u_dut (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode), .baseSel(baseSel),
    .idxSel(idxSel), .konst(konst), .sizeCode(sizeCode), .regWrEn(regWrEn),
    .regWrSel(regWrSel), .regWrData(regWrData), .memReq(memReq),
    .memAddr(memAddr), .memRdata(memRdata), .busy(busy), .done(done),
    .illegal(illegal), .operand(operand)
  );

  function automatic logic [31:0] memFn(input logic [31:0] a);
    return (a * 32'h0100_0193) ^ 32'hA5A5_0F0F;
  endfunction

  int          cyc = 0;
  int          readTotal = 0;
  logic        prevReq = 1'b0;
  logic [31:0] firstAddr = '0;

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memReq) begin
      memRdata  <= memFn(memAddr);
      readTotal <= readTotal + 1;
      if (!prevReq) firstAddr <= memAddr;
    end
    prevReq <= memReq;
  end

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [31:0] op;
    logic        ill;
    int          lat;
    int          reads;
    logic [31:0] addr;
    int          issueCyc;
    int          readsAt;
    string       req;
  } exp_t;

  exp_t        sbQ[$];
  logic [31:0] model [8];

  // monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      if (sbQ.size() == 0) begin
        chk(1'b0, "R12", "done with nothing outstanding", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sbQ.pop_front();
        chk(operand === e.op, e.req, "operand", operand, e.op);
        chk(illegal === e.ill, e.ill ? "R11" : "R12", "illegal flag", 32'(illegal), 32'(e.ill));
        chk((cyc - e.issueCyc) == e.lat, e.req, "latency", 32'(cyc - e.issueCyc), 32'(e.lat));
        chk((readTotal - e.readsAt) == e.reads, e.req, "read count",
            32'(readTotal - e.readsAt), 32'(e.reads));
        if (e.reads > 0)
          chk(firstAddr === e.addr, e.req, "first read address", firstAddr, e.addr);
      end
    end
  end

  // driver: starts at a negedge, returns at a negedge
  task automatic issue(input logic [3:0] m, input int b, input int i,
                       input logic [31:0] k, input int sz, input string req,
                       input bit poke = 1'b0);
    exp_t        e;
    logic [31:0] d;
    d         = 32'd1 << sz;
    e.ill     = 1'b0;
    e.lat     = 3;
    e.reads   = 1;
    e.addr    = '0;
    e.req     = req;
    case (m)
      4'd0: begin e.op = model[b]; e.lat = 2; e.reads = 0; end
      4'd1: begin e.op = k; e.lat = 2; e.reads = 0; end
      4'd2: begin e.addr = k + model[b]; e.op = memFn(e.addr); end
      4'd3: begin e.addr = model[b]; e.op = memFn(e.addr); end
      4'd4: begin e.addr = model[b] + model[i]; e.op = memFn(e.addr); end
      4'd5: begin e.addr = k; e.op = memFn(e.addr); end
      4'd6: begin e.addr = model[b]; e.op = memFn(memFn(e.addr)); e.lat = 4; e.reads = 2; end
      4'd7: begin e.addr = model[b]; e.op = memFn(e.addr); model[b] = model[b] + d; end
      4'd8: begin e.addr = model[b]; e.op = memFn(e.addr); model[b] = model[b] - d; end
      4'd9: begin e.addr = k + model[b] + (model[i] << sz); e.op = memFn(e.addr); end
      default: begin e.op = '0; e.ill = 1'b1; e.lat = 2; e.reads = 0; end
    endcase
    e.issueCyc = cyc;
    e.readsAt  = readTotal;
    sbQ.push_back(e);
    mode = m; baseSel = 3'(b); idxSel = 3'(i); konst = k; sizeCode = 2'(sz);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      chk(busy === 1'b1, "R12", "busy while in flight", 32'(busy), 32'd1);
      mode = 4'd1; konst = 32'h0BAD_0BAD; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (sbQ.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic writeReg(input int r, input logic [31:0] v);
    regWrEn = 1'b1; regWrSel = 3'(r); regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
    model[r] = v;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: run still going at cycle %0d, expected end before %0d", cyc, 20000);
    finishRun();
  end

  initial begin
    for (int r = 0; r < 8; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(done === 1'b0, "R1", "done after reset", 32'(done), 32'd0);
    chk(busy === 1'b0, "R1", "busy after reset", 32'(busy), 32'd0);
    chk(illegal === 1'b0, "R1", "illegal after reset", 32'(illegal), 32'd0);
    chk(memReq === 1'b0, "R1", "memReq after reset", 32'(memReq), 32'd0);
    chk(operand === 32'd0, "R1", "operand after reset", operand, 32'd0);
    issue(4'd0, 7, 0, '0, 0, "R1");

    // R13 external writes, read back through register mode
    writeReg(1, 32'h0000_1000);
    writeReg(2, 32'h0000_0020);
    writeReg(3, 32'h0000_0007);
    writeReg(4, 32'h0000_3000);
    writeReg(5, 32'hFFFF_FFF0);
    issue(4'd0, 5, 0, '0, 0, "R13");
    issue(4'd0, 1, 0, '0, 0, "R2");
    issue(4'd1, 0, 0, 32'hDEAD_BEEF, 0, "R3");
    issue(4'd2, 1, 0, 32'h0000_0040, 0, "R4");
    issue(4'd2, 5, 0, 32'hFFFF_FFFC, 0, "R4");
    issue(4'd3, 4, 0, '0, 0, "R5");
    issue(4'd4, 1, 2, '0, 0, "R5");
    issue(4'd5, 0, 0, 32'h0000_1234, 0, "R6");
    issue(4'd6, 4, 0, '0, 0, "R7");

    // R8 / R9 base update, observed through a following register fetch
    issue(4'd7, 1, 0, '0, 2, "R8");
    issue(4'd0, 1, 0, '0, 0, "R8");
    issue(4'd7, 1, 0, '0, 3, "R8");
    issue(4'd0, 1, 0, '0, 0, "R8");
    issue(4'd8, 4, 0, '0, 0, "R9");
    issue(4'd0, 4, 0, '0, 0, "R9");
    issue(4'd8, 4, 0, '0, 1, "R9");
    issue(4'd0, 4, 0, '0, 0, "R9");

    // R10 every scale factor
    for (int s = 0; s < 4; s++) issue(4'd9, 1, 3, 32'h0000_0010, s, "R10");

    // R11 reserved codes, then registers unchanged
    for (int m = 10; m < 16; m++) issue(4'(m), 1, 2, 32'h5555_AAAA, 1, "R11");
    issue(4'd0, 1, 0, '0, 0, "R11");
    issue(4'd0, 4, 0, '0, 0, "R11");

    // R12 start while busy has no effect
    issue(4'd6, 2, 0, '0, 0, "R12", 1'b1);
    repeat (4) @(negedge clk);
    chk(done === 1'b0, "R12", "no extra completion", 32'(done), 32'd0);
    chk(sbQ.size() == 0, "R12", "scoreboard drained", 32'(sbQ.size()), 32'd0);

    finishRun();
  end

endmodule